// File: doc/BRIEF.md
# Input Sample-Rate Estimator With Lock

This block measures how fast stereo sample strobes arrive from an external push source, relative to a fixed 48 kHz output-rate reference that it derives from the system clock. It produces a 25-bit ratio scaled so that the input rate equals 48 kHz multiplied by the ratio and divided by 2^24. It also produces a lock flag that shows whether that estimate has settled. A downstream rate converter uses the ratio. The lock flag gates the audio path to the mixer.

The estimator counts input strobes over a window of output-rate ticks whose length is a power of two. It scales that count into a raw ratio and smooths it with a first-order filter whose coefficient is a right shift. Lock is granted after the filtered value has moved by no more than a small tolerance for a set number of consecutive windows. Lock is withdrawn when a raw measurement strays beyond a wider tolerance, or when no strobe has arrived for a full window. While lock is absent the samples passed to the mixer are forced to zero, whatever the user mute input says. Everything is held cleared while the enable input is low.

Top module: `rate_lock_est`

## Requirements
- R1: While `enable` is low (and after reset), `ratio` is 0, `locked` is 0 and both mix outputs are 0.
- R2: One output tick occurs every TICK_DIV clocks, and a window is 2^WIN_LOG2 ticks. The raw ratio is the strobe count of a window shifted left by 24-WIN_LOG2. With strobes every P clocks, the settled `ratio` lies within 4*LOCK_TOL of TICK_DIV*2^24/P.
- R3: A raw ratio above 2^25-1 saturates to 2^25-1, so the settled `ratio` approaches all ones and never wraps.
- R4: `ratio` changes only in the cycle after a window ends. The first window after enable loads the raw value. Each later window adds (raw - ratio) arithmetically shifted right by ALPHA_SH.
- R5: `locked` rises only at a window end, after LOCK_WINS consecutive filter steps of at most LOCK_TOL. It is therefore never high earlier than LOCK_WINS+1 windows after enable.
- R6: When `locked` is high and a raw measurement differs from the filtered ratio by more than DROP_TOL, `locked` falls at that window end. It rises again once the estimate has settled at the new rate.
- R7: If no strobe arrives for 2^WIN_LOG2 ticks, `locked` is cleared, and it stays low until strobes resume.
- R8: While `locked` is low, `mix_left` and `mix_right` are 0 regardless of `user_mute`.
- R9: While `locked` is high, `mix_left`/`mix_right` carry the pair captured on the latest strobe when `user_mute` is 0, and are 0 when `user_mute` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Port enable; low holds everything cleared |
| user_mute | input | 1 | User mute request for the mixer path |
| in_strobe | input | 1 | One-cycle pulse per incoming stereo sample |
| in_left | input | 16 | Left sample, valid with the strobe |
| in_right | input | 16 | Right sample, valid with the strobe |
| ratio | output | 25 | Filtered rate ratio, input rate = 48 kHz * ratio / 2^24 |
| locked | output | 1 | Estimate has settled |
| mix_left | output | 16 | Left sample toward the mixer |
| mix_right | output | 16 | Right sample toward the mixer |

## Verification
Strobe periods of 8, 4 and 2 clocks are run in sequence. The first two show that the ratio scales inversely with the period, and the third shows that saturation replaces wraparound. The step from 8 to 4 is large enough to force a loss of lock and a later relock. After that, periods drawn at random from 4, 8, 16 and 32 include small steps that must retune the ratio without dropping lock. Random sample values paired with each user mute setting separate the unlocked mute from the user mute. Stopping the strobes shows that lock clears on starvation and stays low.

// File: rtl/rate_lock_pkg.sv
package rate_lock_pkg;
  localparam int RATIO_W = 25;
  localparam int FRAC_SH = 24;
  typedef logic [RATIO_W-1:0] ratio_t;
  localparam ratio_t RATIO_MAX = {RATIO_W{1'b1}};

  // strobe count of one window -> ratio with 24 fractional bits, saturating
  function automatic ratio_t scale_count(input logic [31:0] n, input int win_log2);
    logic [63:0] wide;
    wide = 64'(n) << (FRAC_SH - win_log2);
    if (wide > 64'(RATIO_MAX)) return RATIO_MAX;
    return wide[RATIO_W-1:0];
  endfunction

  // first-order smoothing: move toward raw by (raw - filt) / 2^sh
  function automatic ratio_t smooth(input ratio_t filt, input ratio_t raw, input int sh);
    logic signed [RATIO_W:0] d;
    logic signed [RATIO_W:0] s;
    d = $signed({1'b0, raw}) - $signed({1'b0, filt});
    d = d >>> sh;
    s = $signed({1'b0, filt}) + d;
    return s[RATIO_W-1:0];
  endfunction

  function automatic ratio_t abs_diff(input ratio_t a, input ratio_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/rate_lock_ticker.sv
module rate_lock_ticker #(
  parameter int TICK_DIV = 2083,
  parameter int WIN_LOG2 = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick,
  output logic win_done
);
  logic [WIN_LOG2-1:0] win_q;

  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign tick = enable;
    end else begin : g_div
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] div_q;
      assign tick = enable && (div_q == DIV_W'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (!enable) div_q <= '0;
        else if (tick)    div_q <= '0;
        else              div_q <= div_q + 1'b1;
      end
    end
  endgenerate

  assign win_done = tick && (win_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       win_q <= '0;
    else if (!enable) win_q <= '0;
    else if (tick)    win_q <= win_q + 1'b1;
  end
endmodule

// File: rtl/rate_lock_counter.sv
module rate_lock_counter #(
  parameter int WIN_LOG2 = 10,
  parameter int CNT_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             strobe,
  input  logic             tick,
  input  logic             win_done,
  output logic [CNT_W-1:0] win_count,
  output logic             stale
);
  logic [CNT_W-1:0]  acc_q;
  logic [WIN_LOG2:0] gap_q;

  // count including a strobe that lands in the closing cycle
  assign win_count = acc_q + CNT_W'(strobe);
  assign stale     = gap_q[WIN_LOG2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (!enable)  acc_q <= '0;
    else if (win_done) acc_q <= '0;
    else               acc_q <= win_count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap_q <= '0;
    else if (!enable)        gap_q <= '0;
    else if (strobe)         gap_q <= '0;
    else if (tick && !stale) gap_q <= gap_q + 1'b1;
  end
endmodule

// File: rtl/rate_lock_tracker.sv
module rate_lock_tracker
  import rate_lock_pkg::*;
#(
  parameter int WIN_LOG2  = 10,
  parameter int CNT_W     = 24,
  parameter int ALPHA_SH  = 2,
  parameter int LOCK_TOL  = 4096,
  parameter int DROP_TOL  = 65536,
  parameter int LOCK_WINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             win_done,
  input  logic             stale,
  input  logic [CNT_W-1:0] win_count,
  output ratio_t           ratio,
  output logic             locked,
  output logic             step_small,
  output logic             drop_hit
);
  localparam int STAB_W = (LOCK_WINS > 1) ? $clog2(LOCK_WINS) : 1;

  ratio_t raw_ratio, filt_q, filt_nxt;
  logic   seeded_q, locked_q;
  logic [STAB_W-1:0] stab_q;

  assign raw_ratio  = scale_count(32'(win_count), WIN_LOG2);
  assign filt_nxt   = smooth(filt_q, raw_ratio, ALPHA_SH);
  assign step_small = abs_diff(filt_nxt, filt_q) <= ratio_t'(LOCK_TOL);
  assign drop_hit   = abs_diff(raw_ratio, filt_q) > ratio_t'(DROP_TOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !enable) begin
      filt_q   <= '0;
      seeded_q <= 1'b0;
      locked_q <= 1'b0;
      stab_q   <= '0;
    end else begin
      if (win_done) begin
        if (!seeded_q) begin
          filt_q   <= raw_ratio;
          seeded_q <= 1'b1;
          stab_q   <= '0;
        end else begin
          filt_q <= filt_nxt;
          if (locked_q && drop_hit) begin
            locked_q <= 1'b0;
            stab_q   <= '0;
          end else if (step_small) begin
            if (stab_q == STAB_W'(LOCK_WINS - 1)) locked_q <= 1'b1;
            else                                  stab_q   <= stab_q + 1'b1;
          end else begin
            stab_q <= '0;
          end
        end
      end
      if (stale) begin
        locked_q <= 1'b0;
        stab_q   <= '0;
      end
    end
  end

  assign ratio  = filt_q;
  assign locked = locked_q;
endmodule

// File: rtl/rate_lock_est.sv
module rate_lock_est #(
  parameter int TICK_DIV  = 2083,
  parameter int WIN_LOG2  = 10,
  parameter int ALPHA_SH  = 2,
  parameter int LOCK_TOL  = 4096,
  parameter int DROP_TOL  = 65536,
  parameter int LOCK_WINS = 8,
  parameter int SAMPLE_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                user_mute,
  input  logic                in_strobe,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic [24:0]         ratio,
  output logic                locked,
  output logic [SAMPLE_W-1:0] mix_left,
  output logic [SAMPLE_W-1:0] mix_right
);
  localparam int CNT_W = WIN_LOG2 + $clog2(TICK_DIV + 1) + 1;

  logic             tick, win_done, stale, step_small, drop_hit, pass;
  logic [CNT_W-1:0] win_count;
  logic [SAMPLE_W-1:0] hold_l, hold_r;

  rate_lock_ticker #(.TICK_DIV(TICK_DIV), .WIN_LOG2(WIN_LOG2)) u_ticker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .win_done(win_done)
  );

  rate_lock_counter #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe(in_strobe), .tick(tick),
    .win_done(win_done), .win_count(win_count), .stale(stale)
  );

  rate_lock_tracker #(
    .WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W), .ALPHA_SH(ALPHA_SH),
    .LOCK_TOL(LOCK_TOL), .DROP_TOL(DROP_TOL), .LOCK_WINS(LOCK_WINS)
  ) u_tracker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .win_done(win_done), .stale(stale),
    .win_count(win_count), .ratio(ratio), .locked(locked),
    .step_small(step_small), .drop_hit(drop_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (!enable) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (in_strobe) begin
      hold_l <= in_left;
      hold_r <= in_right;
    end
  end

  // lock absence overrides the user mute
  assign pass      = enable && locked && !user_mute;
  assign mix_left  = pass ? hold_l : '0;
  assign mix_right = pass ? hold_r : '0;
endmodule

// File: rtl/rate_lock_checker.sv
module rate_lock_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        user_mute,
  input logic [24:0] ratio,
  input logic        locked,
  input logic [15:0] mix_left,
  input logic [15:0] mix_right,
  input logic        win_done,
  input logic        stale
);
  p_disabled_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!locked && ratio == 25'd0));

  p_ratio_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$past(win_done)) |-> $stable(ratio));

  p_lock_on_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(win_done));

  p_stale_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stale |=> !locked);

  p_mute_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (mix_left == 16'd0 && mix_right == 16'd0));

  p_user_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    user_mute |-> (mix_left == 16'd0 && mix_right == 16'd0));
endmodule

bind rate_lock_est rate_lock_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .user_mute(user_mute),
  .ratio(ratio), .locked(locked), .mix_left(mix_left), .mix_right(mix_right),
  .win_done(win_done), .stale(stale)
);

// File: tb/rate_lock_est_bench.sv
module rate_lock_est_bench;
  localparam int TICK_DIV  = 4;
  localparam int WIN_LOG2  = 4;
  localparam int ALPHA_SH  = 2;
  localparam int LOCK_TOL  = 1 << 16;
  localparam int DROP_TOL  = 1 << 22;
  localparam int LOCK_WINS = 4;
  localparam int WIN_CYC   = TICK_DIV << WIN_LOG2;

  logic clk = 0, rst_n = 0, enable = 0, user_mute = 0, in_strobe = 0;
  logic [15:0] in_left = 0, in_right = 0;
  logic [24:0] ratio;
  logic locked;
  logic [15:0] mix_left, mix_right;

  int n_checks = 0, n_fail = 0;
  int per = 8;
  bit run = 0, finished = 0;
  int ph = 0;
  logic [15:0] cap_l = 0, cap_r = 0;
  logic [24:0] prev_ratio = 0;
  bit mon = 0;
  int changes = 0;

  always #2 clk = ~clk;

  rate_lock_est #(
    .TICK_DIV(TICK_DIV), .WIN_LOG2(WIN_LOG2), .ALPHA_SH(ALPHA_SH),
    .LOCK_TOL(LOCK_TOL), .DROP_TOL(DROP_TOL), .LOCK_WINS(LOCK_WINS)
  ) u_rate_lock_est (
    .clk(clk), .rst_n(rst_n), .enable(enable), .user_mute(user_mute),
    .in_strobe(in_strobe), .in_left(in_left), .in_right(in_right),
    .ratio(ratio), .locked(locked), .mix_left(mix_left), .mix_right(mix_right)
  );

  // strobe source, driven on the falling edge
  always @(negedge clk) begin
    if (!run) begin
      ph = 0;
      in_strobe = 0;
    end else if (ph >= per - 1) begin
      ph = 0;
      in_strobe = 1;
      in_left = 16'($urandom);
      in_right = 16'($urandom);
    end else begin
      ph = ph + 1;
      in_strobe = 0;
    end
  end

  // expected captured pair
  always @(posedge clk) if (in_strobe && enable) begin
    cap_l <= in_left;
    cap_r <= in_right;
  end

  always @(negedge clk) begin
    if (mon && ratio != prev_ratio) changes = changes + 1;
    prev_ratio = ratio;
  end

  function automatic longint exp_ratio(input int p);
    longint v;
    v = (longint'(TICK_DIV) << 24) / p;
    if (v > 33554431) v = 33554431;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_ratio(input string req, input int p);
    longint e, d;
    e = exp_ratio(p);
    d = longint'(ratio) - e;
    if (d < 0) d = -d;
    check(d <= 4 * LOCK_TOL, req, "settled ratio", longint'(ratio), e);
  endtask

  task automatic check_mix(input string req, input bit muted);
    longint act, exp;
    act = {mix_left, mix_right};
    exp = muted ? 0 : {cap_l, cap_r};
    check(act == exp, req, muted ? "mix forced to zero" : "mix carries sample", act, exp);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h0005EED1;
    void'($urandom(seed));
    step(5);
    check(ratio == 0 && locked == 0, "R1", "reset ratio/lock", {ratio, locked}, 0);
    check({mix_left, mix_right} == 0, "R1", "reset mix", {mix_left, mix_right}, 0);
    rst_n = 1;
    per = 8; run = 1;
    step(300);
    check(ratio == 0 && locked == 0, "R1", "disabled with strobes", {ratio, locked}, 0);

    // enable, lock must not appear before LOCK_WINS+1 windows
    @(negedge clk); enable = 1;
    step((LOCK_WINS + 1) * WIN_CYC - 8);
    check(locked == 0, "R5", "no early lock", locked, 0);
    check_mix("R8", 1'b1);
    step(30 * WIN_CYC);
    check(locked == 1, "R5", "lock after settling", locked, 1);
    check_ratio("R2", 8);
    step(3); check_mix("R9", 1'b0);
    user_mute = 1; step(5); check_mix("R9", 1'b1);
    user_mute = 0; step(5); check_mix("R9", 1'b0);

    // large rate change: lock drops, then relocks
    per = 4; mon = 1; changes = 0;
    step(2 * WIN_CYC + 8);
    check(locked == 0, "R6", "lock dropped on rate change", locked, 0);
    check_mix("R8", 1'b1);
    step(8 * WIN_CYC);
    mon = 0;
    check(changes <= 11, "R4", "ratio updates per window only", changes, 11);
    step(22 * WIN_CYC);
    check(locked == 1, "R6", "relock at new rate", locked, 1);
    check_ratio("R2", 4);

    // saturation
    per = 2;
    step(35 * WIN_CYC);
    check(locked == 1, "R3", "locked at saturated rate", locked, 1);
    check_ratio("R3", 2);

    // random rates, including small steps
    for (int i = 0; i < 5; i++) begin
      per = 4 << ($urandom % 4);
      user_mute = 1'($urandom);
      step(32 * WIN_CYC);
      check(locked == 1, "R2", "locked at random rate", locked, 1);
      check_ratio("R2", per);
      check_mix("R9", user_mute);
    end
    user_mute = 0;

    // starvation
    run = 0;
    step(WIN_CYC + 2 * TICK_DIV + 4);
    check(locked == 0, "R7", "lock cleared on starvation", locked, 0);
    step(10 * WIN_CYC);
    check(locked == 0, "R7", "stays unlocked without strobes", locked, 0);
    check_mix("R8", 1'b1);

    @(negedge clk); enable = 0;
    step(3);
    check(ratio == 0 && locked == 0, "R1", "disable clears", {ratio, locked}, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule